// File: doc/BRIEF.md
# Timer-Triggered Pattern Output Stage

This block drives an 8-bit output port from a value staged ahead of time. Software loads a next-pattern register and a per-bit transfer mask. When the chosen timer compare-match strobe arrives, each masked-in bit of the port takes its staged value and every other bit keeps its current level. A 2-bit trigger select in a control register picks one of four compare-match strobes. All registers sit on a small 2-bit-offset register bus with combinational reads.

The stage contains a small power-mode state machine. Its three states are `PM_RUN`, `PM_SW_STBY` and `PM_HW_STBY`. The transitions are:
- RUN→HW_STBY when `hw_stby` is high.
- RUN→SW_STBY when `sw_stby` is high and `hw_stby` is low.
- SW_STBY→HW_STBY when `hw_stby` is high.
- SW_STBY→RUN when `sw_stby` is low.
- HW_STBY→SW_STBY when `hw_stby` is low and `sw_stby` is high.
- HW_STBY→RUN when both are low.

In any standby state, bus writes and transfers are ignored. Hardware standby also clears the transfer mask. Software standby keeps the mask.

Top module: `pattern_out_stage`

## Requirements
- R1: After reset, all four offsets read 0x00, `port_out` is 0x00, the trigger select is 0 and the state is `PM_RUN`.
- R2: Offset 0 holds the next pattern, offset 1 the transfer mask, offset 2 the port data and offset 3 the control register. In the control register, bits [1:0] are the trigger select and bits [7:2] read 0. Reads are combinational and have no side effects.
- R3: In `PM_RUN`, a clock edge at which strobe[select] is high and was low at the previous edge is a trigger. At that edge, each port bit whose mask bit is 1 takes the matching next-pattern bit.
- R4: A port bit whose mask bit is 0 keeps its value on a trigger.
- R5: A strobe held high for several cycles causes exactly one transfer.
- R6: Strobes other than the selected one cause no transfer.
- R7: A bus write to the port data offset at the same edge as a trigger sets all eight port bits to the written data.
- R8: While the state is `PM_HW_STBY`, the mask is cleared to 0x00 and stays 0x00. The next-pattern, port data and select registers keep their values.
- R9: While the state is `PM_SW_STBY`, all registers keep their values, including the mask. Bus writes and triggers are ignored.
- R10: `hw_stby` takes priority over `sw_stby`: with both high, the next state is `PM_HW_STBY`.
- R11: When both standby inputs go low, the state returns to `PM_RUN` at the next edge. From then on, writes are accepted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_stby | input | 1 | Hardware standby request (level) |
| sw_stby | input | 1 | Software standby request (level) |
| addr | input | 2 | Register offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| cmp_strobe | input | 4 | Timer compare-match strobes |
| port_out | output | 8 | Port data driven to pins |

## Verification
The bench mixes masks so that a single transfer shows both copied and held bits. A design that ignores the mask would overwrite held bits, and one that inverts it would swap which bits move. A strobe is held high across a change of the next pattern: a level-triggered design would copy the pattern a second time. A strobe is also pulsed on a channel that is not selected, and a port write is made to coincide with a trigger, so that wrong channel decoding or the wrong collision winner shows up at `port_out`. The two standby modes are entered in turn, and the mask is read back after each. A design that clears the mask in software standby, keeps it in hardware standby, or accepts writes while parked would read back the wrong value.

// File: rtl/pos_pkg.sv
package pos_pkg;

    typedef enum logic [1:0] {
        PM_RUN     = 2'd0,
        PM_SW_STBY = 2'd1,
        PM_HW_STBY = 2'd2
    } pm_state_e;

    localparam int unsigned OFS_W = 2;

    localparam logic [OFS_W-1:0] OFS_NEXT   = 2'd0;
    localparam logic [OFS_W-1:0] OFS_MASK   = 2'd1;
    localparam logic [OFS_W-1:0] OFS_PORT   = 2'd2;
    localparam logic [OFS_W-1:0] OFS_CTRL   = 2'd3;

endpackage

// File: rtl/pos_power_fsm.sv
module pos_power_fsm
    import pos_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_stby_i,
    input  logic sw_stby_i,
    output logic run_o,
    output logic clr_o
);

    pm_state_e state_q;
    pm_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PM_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RUN: begin
                if (hw_stby_i) begin
                    state_d = PM_HW_STBY;
                end else if (sw_stby_i) begin
                    state_d = PM_SW_STBY;
                end
            end
            PM_SW_STBY: begin
                if (hw_stby_i) begin
                    state_d = PM_HW_STBY;
                end else if (!sw_stby_i) begin
                    state_d = PM_RUN;
                end
            end
            PM_HW_STBY: begin
                if (!hw_stby_i) begin
                    state_d = sw_stby_i ? PM_SW_STBY : PM_RUN;
                end
            end
            default: state_d = PM_RUN;
        endcase
    end

    // Moore outputs
    always_comb begin
        run_o = 1'b0;
        clr_o = 1'b0;
        unique case (state_q)
            PM_RUN:     run_o = 1'b1;
            PM_SW_STBY: ;
            PM_HW_STBY: clr_o = 1'b1;
            default:    ;
        endcase
    end

    // R10: hardware standby wins over software standby
    assert_hw_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby_i |=> (state_q == PM_HW_STBY));

    // R11: both requests low returns to run
    assert_exit_to_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_stby_i && !sw_stby_i) |=> run_o);

endmodule

// File: rtl/pos_trig_sel.sv
module pos_trig_sel #(
    parameter int unsigned NUM_STROBES = 4,
    parameter int unsigned SEL_W       = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_STROBES-1:0] strobe_i,
    input  logic [SEL_W-1:0]       sel_i,
    output logic                   trig_o
);

    logic picked;
    logic picked_q;

    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < NUM_STROBES; i++) begin
            if (int'(sel_i) == i) begin
                picked = strobe_i[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            picked_q <= 1'b0;
        end else begin
            picked_q <= picked;
        end
    end

    assign trig_o = picked & ~picked_q;

    // R5: a trigger never lasts two consecutive cycles
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

endmodule

// File: rtl/pos_regfile.sv
module pos_regfile
    import pos_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              clr_i,
    input  logic              trig_i,
    input  logic [OFS_W-1:0]  addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] port_o,
    output logic [SEL_W-1:0]  sel_o
);

    localparam int unsigned PAD_W = DATA_W - SEL_W;

    logic [DATA_W-1:0] nd_q;
    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] pd_q;
    logic [SEL_W-1:0]  sel_q;

    logic wr_nd, wr_en_reg, wr_pd, wr_ctl;

    assign wr_nd     = run_i && wr_en_i && (addr_i == OFS_NEXT);
    assign wr_en_reg = run_i && wr_en_i && (addr_i == OFS_MASK);
    assign wr_pd     = run_i && wr_en_i && (addr_i == OFS_PORT);
    assign wr_ctl    = run_i && wr_en_i && (addr_i == OFS_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nd_q <= '0;
        end else if (wr_nd) begin
            nd_q <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (clr_i) begin
            en_q <= '0;
        end else if (wr_en_reg) begin
            en_q <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr_ctl) begin
            sel_q <= wdata_i[SEL_W-1:0];
        end
    end

    // Per-bit port data: bus write first, then masked transfer
    for (genvar b = 0; b < DATA_W; b++) begin : g_port_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pd_q[b] <= 1'b0;
            end else if (wr_pd) begin
                pd_q[b] <= wdata_i[b];
            end else if (run_i && trig_i && en_q[b]) begin
                pd_q[b] <= nd_q[b];
            end
        end
    end

    always_comb begin
        unique case (addr_i)
            OFS_NEXT: rdata_o = nd_q;
            OFS_MASK: rdata_o = en_q;
            OFS_PORT: rdata_o = pd_q;
            OFS_CTRL: rdata_o = {{PAD_W{1'b0}}, sel_q};
            default:  rdata_o = '0;
        endcase
    end

    assign port_o = pd_q;
    assign sel_o  = sel_q;

    // R3: enabled bits take the staged pattern on a trigger
    assert_masked_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && trig_i && !(wr_en_i && addr_i == OFS_PORT))
        |=> ((pd_q & $past(en_q)) == ($past(nd_q) & $past(en_q))));

    // R4: disabled bits never move on a trigger
    assert_disabled_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && trig_i && !(wr_en_i && addr_i == OFS_PORT))
        |=> (((pd_q ^ $past(pd_q)) & ~$past(en_q)) == '0));

    // R7: a bus write to the port wins over a concurrent transfer
    assert_cpu_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && wr_en_i && addr_i == OFS_PORT) |=> (pd_q == $past(wdata_i)));

    // R8: hardware standby clears the mask
    assert_hw_clears_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (en_q == '0));

    // R9: software standby freezes every register
    assert_sw_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clr_i) |=> ($stable(nd_q) && $stable(en_q) && $stable(pd_q) && $stable(sel_q)));

endmodule

// File: rtl/pattern_out_stage.sv
module pattern_out_stage
    import pos_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned NUM_STROBES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hw_stby,
    input  logic                   sw_stby,
    input  logic [OFS_W-1:0]       addr,
    input  logic                   wr_en,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    input  logic [NUM_STROBES-1:0] cmp_strobe,
    output logic [DATA_W-1:0]      port_out
);

    localparam int unsigned SEL_W = (NUM_STROBES > 1) ? $clog2(NUM_STROBES) : 1;

    logic             run;
    logic             clr;
    logic             trig;
    logic [SEL_W-1:0] sel;

    pos_power_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_stby_i (hw_stby),
        .sw_stby_i (sw_stby),
        .run_o     (run),
        .clr_o     (clr)
    );

    pos_trig_sel #(
        .NUM_STROBES (NUM_STROBES),
        .SEL_W       (SEL_W)
    ) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (cmp_strobe),
        .sel_i    (sel),
        .trig_o   (trig)
    );

    pos_regfile #(
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .clr_i   (clr),
        .trig_i  (trig),
        .addr_i  (addr),
        .wr_en_i (wr_en),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .port_o  (port_out),
        .sel_o   (sel)
    );

endmodule

// File: tb/pattern_out_stage_tb.sv
module pattern_out_stage_tb_top;

    typedef struct {
        bit         is_port;
        logic [1:0] ofs;
        logic [7:0] exp;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_stby = 1'b0;
    logic       sw_stby = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] cmp_strobe = '0;
    logic [7:0] port_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    item_t sb[$];

    always #2.5 clk = ~clk;

    pattern_out_stage dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_stby    (hw_stby),
        .sw_stby    (sw_stby),
        .addr       (addr),
        .wr_en      (wr_en),
        .wdata      (wdata),
        .rdata      (rdata),
        .cmp_strobe (cmp_strobe),
        .port_out   (port_out)
    );

    // Monitor: pops expected items and compares away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [7:0] got;
            it  = sb.pop_front();
            got = it.is_port ? port_out : rdata;
            n_vec++;
            if (got !== it.exp) begin
                n_bad++;
                $display("FAIL %s: %s got %02h expected %02h", it.req,
                         it.is_port ? "port_out" : "rdata", got, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int idx);
        cmp_strobe[idx] = 1'b1;
        tick();
        cmp_strobe = '0;
    endtask

    task automatic chk(input logic [1:0] a, input logic [7:0] e, input string req);
        item_t it;
        it.is_port = 1'b0; it.ofs = a; it.exp = e; it.req = req;
        addr = a;
        sb.push_back(it);
        tick();
    endtask

    task automatic chk_port(input logic [7:0] e, input string req);
        item_t it;
        it.is_port = 1'b1; it.ofs = '0; it.exp = e; it.req = req;
        sb.push_back(it);
        tick();
    endtask

    function automatic logic [7:0] xfer(input logic [7:0] pd, input logic [7:0] nd,
                                        input logic [7:0] en);
        return (pd & ~en) | (nd & en);
    endfunction

    initial begin
        logic [7:0] pd;
        #12;
        rst_n = 1'b1;
        tick();
        // R1 reset state
        for (int i = 0; i < 4; i++) chk(2'(i), 8'h00, "R1");
        chk_port(8'h00, "R1");

        // R2 register map and control padding
        wr(2'd0, 8'hA5);
        wr(2'd1, 8'h0F);
        wr(2'd2, 8'h3C);
        wr(2'd3, 8'hFF);
        chk(2'd3, 8'h03, "R2");
        wr(2'd3, 8'h01);
        chk(2'd0, 8'hA5, "R2");
        chk(2'd1, 8'h0F, "R2");
        chk(2'd3, 8'h01, "R2");
        pd = 8'h3C;

        // R6 unselected strobe ignored
        pulse(0);
        pulse(2);
        chk_port(pd, "R6");

        // R3/R4 masked transfer on strobe 1
        pulse(1);
        pd = xfer(pd, 8'hA5, 8'h0F);
        chk_port(pd, "R3");
        chk(2'd2, 8'h35, "R4");

        // R4 all-disabled mask holds port
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hFF);
        pulse(1);
        chk_port(pd, "R4");

        // R5 held strobe transfers once
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'hC3);
        cmp_strobe[1] = 1'b1;
        tick();
        wr(2'd0, 8'h11);
        tick();
        tick();
        cmp_strobe = '0;
        pd = 8'hC3;
        chk_port(pd, "R5");
        chk(2'd0, 8'h11, "R5");

        // R7 bus write collides with trigger
        wr(2'd0, 8'h00);
        addr = 2'd2; wdata = 8'h5A; wr_en = 1'b1; cmp_strobe[1] = 1'b1;
        tick();
        wr_en = 1'b0; cmp_strobe = '0;
        pd = 8'h5A;
        chk_port(pd, "R7");

        // R9 software standby freezes and keeps the mask
        wr(2'd1, 8'h3C);
        wr(2'd0, 8'hF0);
        sw_stby = 1'b1;
        tick();
        tick();
        wr(2'd0, 8'h77);
        wr(2'd1, 8'h00);
        pulse(1);
        chk(2'd0, 8'hF0, "R9");
        chk(2'd1, 8'h3C, "R9");
        chk_port(pd, "R9");

        // R10/R8 hardware standby with both requests high
        hw_stby = 1'b1;
        tick();
        tick();
        wr(2'd1, 8'hFF);
        pulse(1);
        chk(2'd1, 8'h00, "R8");
        chk(2'd0, 8'hF0, "R8");
        chk_port(pd, "R10");

        // R11 exit returns to run, writes accepted
        hw_stby = 1'b0;
        sw_stby = 1'b0;
        tick();
        tick();
        wr(2'd1, 8'h0F);
        chk(2'd1, 8'h0F, "R11");
        pulse(1);
        pd = xfer(pd, 8'hF0, 8'h0F);
        chk_port(pd, "R11");

        tick();
        tick();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule